// File: doc/BRIEF.md
# Spare Overhead Bit Validator

This block filters the spare overhead bits extracted from each received superframe before they reach the system side. The bits arrive in two independent groups: a narrow group that feeds receive register A and a wider group that feeds receive register B. Every bit has its own persistence filter. A 2-bit mode field in an 8-bit control register sets how strict that filter is: pass every superframe through, accept any change, or accept a change only after it has repeated two or three times.

When a filtered bit changes, the block updates the visible register for its group. It also pulses an interrupt request for that group in the cycle after the superframe strobe. Register B can raise a request for two more reasons, each with its own enable bit: a CRC mismatch, which also clears the near-end error flag, and a received far-end error bit at zero. A single-grant output passes one request on to a downstream interrupt queue, and group A wins when both groups request in the same cycle.

Top module: `ovh_validator`

## Requirements
- R1: After reset the control register reads 0x1E on `cfg_rdata`. A write with `cfg_we` high shows on `cfg_rdata` from the next cycle. Bit 7 enables the CRC interrupt, bit 5 enables the far-end error interrupt and bits 4:3 select the mode. Bit 6 is stored but does not act on this block.
- R2: In mode 00, every `sf_strobe` copies both input groups into `reg_a_q` and `reg_b_q`, and it pulses `irq_a` and `irq_b` for one cycle in the cycle after the strobe.
- R3: In mode 01, a bit takes the newly received value as soon as it differs from the held value. The group's request pulses only when at least one of its bits changed.
- R4: In mode 10, a bit takes a new value only after two consecutive superframes deliver that same value. The group's request pulses in the cycle after the accepting superframe.
- R5: In mode 11 (the reset mode), a bit takes a new value only after three consecutive identical receptions.
- R6: Each bit is filtered on its own. Receiving a value different from a bit's candidate restarts that bit's count. Receiving the held value again clears any pending candidate.
- R7: On every strobe, `nebe_q` is set to the inverse of `crc_mismatch`. When control bit 7 is set, a mismatch also pulses `irq_b`. When bit 7 is clear, a mismatch raises no request.
- R8: On every strobe, `febe_q` takes the value of `febe_bit`. When control bit 5 is set, a zero `febe_bit` pulses `irq_b`. When bit 5 is clear, a zero raises no request.
- R9: `grant_a` follows `irq_a`. `grant_b` is high only when `irq_b` is high and `irq_a` is low. At most one grant is high in any cycle.
- R10: In a cycle without `sf_strobe`, neither register changes and neither request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Current control register value |
| sf_strobe | input | 1 | One-cycle pulse marking a received superframe |
| grp_a_bits | input | A_W (4) | Spare bits for register A |
| grp_b_bits | input | B_W (6) | Spare bits for register B |
| crc_mismatch | input | 1 | Local CRC differs from the received CRC |
| febe_bit | input | 1 | Received far-end error bit (0 means error) |
| reg_a_q | output | A_W | Validated register A |
| reg_b_q | output | B_W | Validated register B |
| nebe_q | output | 1 | Near-end error flag for register B (0 means CRC error) |
| febe_q | output | 1 | Last received far-end error bit |
| irq_a | output | 1 | Request for register A |
| irq_b | output | 1 | Request for register B |
| grant_a | output | 1 | Single-grant output selecting A |
| grant_b | output | 1 | Single-grant output selecting B |

## Verification
The assertions assume that `sf_strobe` is low while reset is asserted and in the cycle in which reset is released. They also assume that the data inputs and the control register are valid in the strobe cycle. The bench changes its inputs only on falling edges and raises the strobe for exactly one cycle at a time. It writes the control register only in cycles without a strobe, so the mode seen at each strobe is the one already shown on `cfg_rdata`.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
   typedef enum logic [1:0] {
      OVH_RAW    = 2'b00,
      OVH_CHANGE = 2'b01,
      OVH_TWICE  = 2'b10,
      OVH_THRICE = 2'b11
   } ovh_mode_e;

   localparam int CTL_W       = 8;
   localparam int CTL_CRC_EN  = 7;
   localparam int CTL_CNT_EN  = 6;
   localparam int CTL_FE_EN   = 5;
   localparam int CTL_MODE_HI = 4;
   localparam int CTL_MODE_LO = 3;
   localparam logic [CTL_W-1:0] CTL_RESET = 8'h1E;

   function automatic logic [1:0] ovh_need(input ovh_mode_e m);
      case (m)
         OVH_CHANGE: return 2'd1;
         OVH_TWICE:  return 2'd2;
         OVH_THRICE: return 2'd3;
         default:    return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/ovh_ctl_reg.sv
module ovh_ctl_reg
   import ovh_pkg::*;
#(
   parameter logic [CTL_W-1:0] RESET_VAL = CTL_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/ovh_bit_filter.sv
module ovh_bit_filter
   import ovh_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  ovh_mode_e mode,
   input  logic      rx_bit,
   output logic      val_q,
   output logic      changed
);
   logic       cand_q;
   logic [1:0] cnt_q;
   logic [1:0] need;
   logic [1:0] next_cnt;
   logic       accept;

   always_comb begin
      need     = ovh_need(mode);
      next_cnt = (rx_bit == cand_q && cnt_q != 2'd3) ? cnt_q + 2'd1 : 2'd1;
      if (mode == OVH_RAW) accept = (rx_bit != val_q);
      else                 accept = (rx_bit != val_q) && (next_cnt >= need);
      changed  = strobe && accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= 1'b0;
         cand_q <= 1'b0;
         cnt_q  <= 2'd0;
      end else if (strobe) begin
         cand_q <= rx_bit;
         if (rx_bit == val_q || accept) begin
            val_q <= rx_bit;
            cnt_q <= 2'd0;
         end else begin
            cnt_q <= next_cnt;
         end
      end
   end
endmodule

// File: rtl/ovh_group.sv
module ovh_group
   import ovh_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  ovh_mode_e    mode,
   input  logic [W-1:0] rx_bits,
   output logic [W-1:0] val_q,
   output logic         any_change
);
   logic [W-1:0] chg;

   for (genvar i = 0; i < W; i++) begin : g_bit
      ovh_bit_filter u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .strobe  (strobe),
         .mode    (mode),
         .rx_bit  (rx_bits[i]),
         .val_q   (val_q[i]),
         .changed (chg[i])
      );
   end

   assign any_change = |chg;
endmodule

// File: rtl/ovh_validator.sv
module ovh_validator
   import ovh_pkg::*;
#(
   parameter int A_W = 4,
   parameter int B_W = 6,
   parameter logic [7:0] CTL_INIT = 8'h1E
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [7:0]     cfg_wdata,
   output logic [7:0]     cfg_rdata,
   input  logic           sf_strobe,
   input  logic [A_W-1:0] grp_a_bits,
   input  logic [B_W-1:0] grp_b_bits,
   input  logic           crc_mismatch,
   input  logic           febe_bit,
   output logic [A_W-1:0] reg_a_q,
   output logic [B_W-1:0] reg_b_q,
   output logic           nebe_q,
   output logic           febe_q,
   output logic           irq_a,
   output logic           irq_b,
   output logic           grant_a,
   output logic           grant_b
);
   initial begin
      if (A_W < 1 || A_W > 8) $error("ovh_validator: A_W out of range");
      if (B_W < 1 || B_W > 8) $error("ovh_validator: B_W out of range");
   end

   ovh_mode_e mode;
   logic      chg_a, chg_b, raw, crc_evt, fe_evt;

   ovh_ctl_reg #(.RESET_VAL(CTL_INIT)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_rdata)
   );

   assign mode = ovh_mode_e'(cfg_rdata[CTL_MODE_HI:CTL_MODE_LO]);

   ovh_group #(.W(A_W)) u_grp_a (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (sf_strobe),
      .mode       (mode),
      .rx_bits    (grp_a_bits),
      .val_q      (reg_a_q),
      .any_change (chg_a)
   );

   ovh_group #(.W(B_W)) u_grp_b (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (sf_strobe),
      .mode       (mode),
      .rx_bits    (grp_b_bits),
      .val_q      (reg_b_q),
      .any_change (chg_b)
   );

   always_comb begin
      raw     = (mode == OVH_RAW);
      crc_evt = cfg_rdata[CTL_CRC_EN] && crc_mismatch;
      fe_evt  = cfg_rdata[CTL_FE_EN] && !febe_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_a  <= 1'b0;
         irq_b  <= 1'b0;
         nebe_q <= 1'b1;
         febe_q <= 1'b1;
      end else begin
         irq_a <= sf_strobe && (raw || chg_a);
         irq_b <= sf_strobe && (raw || chg_b || crc_evt || fe_evt);
         if (sf_strobe) begin
            nebe_q <= !crc_mismatch;
            febe_q <= febe_bit;
         end
      end
   end

   assign grant_a = irq_a;
   assign grant_b = irq_b && !irq_a;
endmodule

// File: rtl/ovh_validator_chk.sv
module ovh_validator_chk #(
   parameter int A_W = 4,
   parameter int B_W = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic [7:0]     cfg_rdata,
   input logic           sf_strobe,
   input logic [A_W-1:0] grp_a_bits,
   input logic [B_W-1:0] grp_b_bits,
   input logic           crc_mismatch,
   input logic           febe_bit,
   input logic [A_W-1:0] reg_a_q,
   input logic [B_W-1:0] reg_b_q,
   input logic           nebe_q,
   input logic           irq_a,
   input logic           irq_b,
   input logic           grant_a,
   input logic           grant_b
);
   AST_IRQ_A_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> $past(sf_strobe)); // R10
   AST_IRQ_B_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> $past(sf_strobe)); // R10
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sf_strobe)) |-> ($stable(reg_a_q) && $stable(reg_b_q))); // R10
   AST_RAW_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sf_strobe) && $past(cfg_rdata[4:3]) == 2'b00) |-> (irq_a && irq_b)); // R2
   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sf_strobe) && $past(cfg_rdata[4:3]) == 2'b00)
      |-> (reg_a_q == $past(grp_a_bits) && reg_b_q == $past(grp_b_bits))); // R2
   AST_CHANGE_RAISES_A: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && reg_a_q != $past(reg_a_q)) |-> irq_a); // R3
   AST_CRC_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sf_strobe && cfg_rdata[7] && crc_mismatch)) |-> (irq_b && !nebe_q)); // R7
   AST_FE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sf_strobe && cfg_rdata[5] && !febe_bit)) |-> irq_b); // R8
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_a, grant_b})); // R9
   AST_GRANT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> grant_a); // R9
endmodule

bind ovh_validator ovh_validator_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_rdata    (cfg_rdata),
   .sf_strobe    (sf_strobe),
   .grp_a_bits   (grp_a_bits),
   .grp_b_bits   (grp_b_bits),
   .crc_mismatch (crc_mismatch),
   .febe_bit     (febe_bit),
   .reg_a_q      (reg_a_q),
   .reg_b_q      (reg_b_q),
   .nebe_q       (nebe_q),
   .irq_a        (irq_a),
   .irq_b        (irq_b),
   .grant_a      (grant_a),
   .grant_b      (grant_b)
);

// File: tb/ovh_validator_tb_top.sv
module ovh_validator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int A_W = 4;
   localparam int B_W = 6;

   typedef struct {
      logic [A_W-1:0] a;
      logic [B_W-1:0] b;
      logic           ia;
      logic           ib;
      logic           ga;
      logic           gb;
      logic           nebe;
      string          tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic sf_strobe = 1'b0;
   logic [A_W-1:0] grp_a_bits = '0;
   logic [B_W-1:0] grp_b_bits = '0;
   logic crc_mismatch = 1'b0;
   logic febe_bit = 1'b1;
   logic [A_W-1:0] reg_a_q;
   logic [B_W-1:0] reg_b_q;
   logic nebe_q, febe_q, irq_a, irq_b, grant_a, grant_b;

   int n_tests = 0;
   int n_fail = 0;
   exp_t sb_q[$];
   logic launched = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ovh_validator #(.A_W(A_W), .B_W(B_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .sf_strobe(sf_strobe), .grp_a_bits(grp_a_bits),
      .grp_b_bits(grp_b_bits), .crc_mismatch(crc_mismatch), .febe_bit(febe_bit),
      .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .nebe_q(nebe_q), .febe_q(febe_q),
      .irq_a(irq_a), .irq_b(irq_b), .grant_a(grant_a), .grant_b(grant_b)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: outputs are valid at the falling edge after the strobe was captured
   always @(posedge clk) launched <= sf_strobe;

   always @(negedge clk) begin
      if (launched && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(reg_a_q == e.a, {e.tag, " reg_a"}, int'(reg_a_q), int'(e.a));
         check(reg_b_q == e.b, {e.tag, " reg_b"}, int'(reg_b_q), int'(e.b));
         check({irq_a, irq_b} == {e.ia, e.ib}, {e.tag, " irq"}, int'({irq_a, irq_b}), int'({e.ia, e.ib}));
         check({grant_a, grant_b} == {e.ga, e.gb}, {e.tag, " R9 grant"}, int'({grant_a, grant_b}), int'({e.ga, e.gb}));
         check(nebe_q == e.nebe, {e.tag, " nebe"}, int'(nebe_q), int'(e.nebe));
      end
   end

   // driver: one superframe, expected result pushed to the scoreboard
   task automatic send_sf(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                          input logic crc, input logic fe,
                          input logic [A_W-1:0] ea, input logic [B_W-1:0] eb,
                          input logic eia, input logic eib, input logic enebe,
                          input string tag);
      exp_t e;
      e.a = ea; e.b = eb; e.ia = eia; e.ib = eib;
      e.ga = eia; e.gb = eib && !eia; e.nebe = enebe; e.tag = tag;
      sb_q.push_back(e);
      grp_a_bits = a; grp_b_bits = b; crc_mismatch = crc; febe_bit = fe;
      sf_strobe = 1'b1;
      @(negedge clk);
      sf_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_wdata = v; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_rdata == v, "R1 cfg write", int'(cfg_rdata), int'(v));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(cfg_rdata == 8'h1E, "R1 reset cfg", int'(cfg_rdata), 32'h1E);
      check(reg_a_q == 0 && reg_b_q == 0, "R1 reset regs", int'(reg_a_q), 0);
      check(!irq_a && !irq_b && nebe_q, "R1 reset irq/nebe", int'({irq_a, irq_b, nebe_q}), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 mode 11: three identical receptions
      send_sf(4'h5, 6'h00, 0, 1, 4'h0, 6'h00, 0, 0, 1, "R5 first");
      send_sf(4'h5, 6'h00, 0, 1, 4'h0, 6'h00, 0, 0, 1, "R5 second");
      send_sf(4'h5, 6'h00, 0, 1, 4'h5, 6'h00, 1, 0, 1, "R5 third");
      // R6 interrupted sequence restarts the count
      send_sf(4'h6, 6'h00, 0, 1, 4'h5, 6'h00, 0, 0, 1, "R6 cand");
      send_sf(4'h5, 6'h00, 0, 1, 4'h5, 6'h00, 0, 0, 1, "R6 back to held");
      send_sf(4'h6, 6'h00, 0, 1, 4'h5, 6'h00, 0, 0, 1, "R6 restart 1");
      send_sf(4'h6, 6'h00, 0, 1, 4'h5, 6'h00, 0, 0, 1, "R6 restart 2");
      send_sf(4'h6, 6'h00, 0, 1, 4'h6, 6'h00, 1, 0, 1, "R6 restart 3");
      // R6 per-bit independence: bit0 and bit3 start at different frames
      send_sf(4'h7, 6'h00, 0, 1, 4'h6, 6'h00, 0, 0, 1, "R6 bit0 1");
      send_sf(4'hF, 6'h00, 0, 1, 4'h6, 6'h00, 0, 0, 1, "R6 bit0 2 bit3 1");
      send_sf(4'hF, 6'h00, 0, 1, 4'h7, 6'h00, 1, 0, 1, "R6 bit0 accepted");
      send_sf(4'hF, 6'h00, 0, 1, 4'hF, 6'h00, 1, 0, 1, "R6 bit3 accepted");

      // R4 mode 10, plus R9 simultaneous requests
      write_cfg(8'h10);
      send_sf(4'h0, 6'h2A, 0, 1, 4'hF, 6'h00, 0, 0, 1, "R4 first");
      send_sf(4'h0, 6'h2A, 0, 1, 4'h0, 6'h2A, 1, 1, 1, "R4 second R9 both");
      send_sf(4'h0, 6'h3F, 0, 1, 4'h0, 6'h2A, 0, 0, 1, "R4 b first");
      send_sf(4'h0, 6'h3F, 0, 1, 4'h0, 6'h3F, 0, 1, 1, "R4 b second R9 b only");

      // R3 mode 01
      write_cfg(8'h08);
      send_sf(4'h0, 6'h3F, 0, 1, 4'h0, 6'h3F, 0, 0, 1, "R3 no change");
      send_sf(4'h1, 6'h3F, 0, 1, 4'h1, 6'h3F, 1, 0, 1, "R3 change");
      send_sf(4'h1, 6'h3F, 0, 1, 4'h1, 6'h3F, 0, 0, 1, "R3 repeat");
      // R7 R8 disabled: no request, flags still follow
      send_sf(4'h1, 6'h3F, 1, 0, 4'h1, 6'h3F, 0, 0, 0, "R7 R8 disabled");
      check(febe_q == 1'b0, "R8 febe_q follows", int'(febe_q), 0);

      // R7 R8 enabled
      write_cfg(8'hA8);
      send_sf(4'h1, 6'h3F, 1, 1, 4'h1, 6'h3F, 0, 1, 0, "R7 crc irq");
      send_sf(4'h1, 6'h3F, 0, 0, 4'h1, 6'h3F, 0, 1, 1, "R8 febe irq");
      send_sf(4'h1, 6'h3F, 0, 1, 4'h1, 6'h3F, 0, 0, 1, "R7 R8 quiet");

      // R2 mode 00 raw
      write_cfg(8'h00);
      send_sf(4'h1, 6'h3F, 0, 1, 4'h1, 6'h3F, 1, 1, 1, "R2 raw same");
      send_sf(4'h9, 6'h05, 0, 1, 4'h9, 6'h05, 1, 1, 1, "R2 raw new");

      // R10 no strobe: nothing moves even with changing inputs
      grp_a_bits = 4'h3; grp_b_bits = 6'h11; crc_mismatch = 1'b1; febe_bit = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(!irq_a && !irq_b, "R10 no irq", int'({irq_a, irq_b}), 0);
      end
      check(reg_a_q == 4'h9 && reg_b_q == 6'h05, "R10 regs held", int'(reg_a_q), 9);
      check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) check(1'b0, "watchdog", cyc, 5000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule